// File: doc/BRIEF.md
# Armed Door Alarm Sequencer

This block is the control core of an intruder alarm. It watches two level inputs: one says the system is armed and the other says a door is open. While the system is disarmed, or while it is armed with the door shut, it rests silently. When the door is seen open while the system is armed, the alarm latches into an active cycle. In that cycle the horn output is high for one clock and low for the next, and this repeats for as long as the system stays armed. Closing the door again does not stop the cycle. Only dropping the arm input silences the horn and returns the block to rest.

The block is meant to run from a slow tick clock, such as 1 Hz, so each horn pulse lasts one tick. Building that slow clock, debouncing the inputs and adding timeouts are the job of the surrounding logic. Internally the block has three states, each with a 2-bit code: rest `00`, sounding `01` and pause `10`. The horn is a pure decode of the state, so it has no pipeline delay.

Top module: `doorAlarm`

## Requirements
- R1: A high `rst` sampled on a rising clock edge puts the block in the rest state, and `horn` reads 0 after that edge. This holds whatever `armed` and `doorOpen` are doing at the time.
- R2: In the rest state, any edge without both `armed`=1 and `doorOpen`=1 leaves the block in rest with `horn`=0.
- R3: In the rest state, an edge with `armed`=1 and `doorOpen`=1 moves the block to sounding, and `horn` is 1 after that edge.
- R4: In the sounding state, an edge with `armed`=1 moves the block to pause, and `horn` is 0 after that edge.
- R5: In the sounding state, an edge with `armed`=0 returns the block to rest.
- R6: In the pause state, an edge with `armed`=1 moves the block back to sounding, and `horn` is 1 after that edge.
- R7: In the pause state, an edge with `armed`=0 returns the block to rest.
- R8: In the sounding and pause states, `doorOpen` has no effect. The next state is decided by `armed` alone.
- R9: `horn` is 1 exactly in the sounding state. While the block stays armed after a trigger, `horn` alternates 1, 0, 1, 0 on successive clocks and is never high on two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| armed | input | 1 | 1 while the alarm system is armed |
| doorOpen | input | 1 | 1 while the guarded door is open |
| horn | output | 1 | Horn drive, high only in the sounding state |

## Verification
The block has no parameters, so the bench builds it as it is. The bench covers the whole product of the three states and the four input combinations. Each combination starts from a fresh reset and is driven into the state under test. After each transition the bench applies a probe clock with the system armed and the door shut. On that probe, rest stays silent, pause starts sounding and sounding falls silent, so every state can be told apart at the horn pin alone. A long armed run then toggles the door on every clock while the horn alternates, and ends by disarming.

// File: rtl/doorAlarmPkg.sv
package doorAlarmPkg;

  // 2-bit state code; 2'b11 is unused and is sent back to rest
  typedef enum logic [1:0] {
    ALM_REST  = 2'b00,
    ALM_SOUND = 2'b01,
    ALM_PAUSE = 2'b10
  } almState_t;

  // strobes from control to the state holder; at most one is high
  typedef struct packed {
    logic goRest;
    logic goSound;
    logic goPause;
  } almStrobe_t;

endpackage

// File: rtl/doorAlarmCtrl.sv
module doorAlarmCtrl
  import doorAlarmPkg::*;
(
  input  almState_t  curState,
  input  logic       armed,
  input  logic       doorOpen,
  output almStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (curState)
      ALM_REST: begin
        if (armed && doorOpen) strobe.goSound = 1'b1;
      end
      ALM_SOUND: begin
        if (armed) strobe.goPause = 1'b1;
        else       strobe.goRest  = 1'b1;
      end
      ALM_PAUSE: begin
        if (armed) strobe.goSound = 1'b1;
        else       strobe.goRest  = 1'b1;
      end
      default: strobe.goRest = 1'b1;
    endcase
  end

  always_comb begin
    strobeExclusive_chk: assert ($onehot0(strobe))
      else $error("more than one state strobe high");
  end

endmodule

// File: rtl/doorAlarmPath.sv
module doorAlarmPath
  import doorAlarmPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  almStrobe_t strobe,
  output almState_t  curState,
  output logic       horn
);

  always_ff @(posedge clk) begin
    if (rst)                 curState <= ALM_REST;
    else if (strobe.goRest)  curState <= ALM_REST;
    else if (strobe.goSound) curState <= ALM_SOUND;
    else if (strobe.goPause) curState <= ALM_PAUSE;
  end

  assign horn = (curState == ALM_SOUND);

  // R9
  honkGap_chk: assert property (@(posedge clk) disable iff (rst)
    horn |=> !horn);

endmodule

// File: rtl/doorAlarm.sv
module doorAlarm
  import doorAlarmPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic doorOpen,
  output logic horn
);

  almState_t  curState;
  almStrobe_t strobe;

  doorAlarmCtrl u_ctrl (
    .curState (curState),
    .armed    (armed),
    .doorOpen (doorOpen),
    .strobe   (strobe)
  );

  doorAlarmPath u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState),
    .horn     (horn)
  );

  // R1
  resetRest_chk: assert property (@(posedge clk)
    rst |=> (curState == ALM_REST));

  // R2
  restHold_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ALM_REST && !(armed && doorOpen)) |=> (curState == ALM_REST));

  // R3
  trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ALM_REST && armed && doorOpen) |=> (curState == ALM_SOUND));

  // R4
  soundToPause_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ALM_SOUND && armed) |=> (curState == ALM_PAUSE));

  // R6
  pauseToSound_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ALM_PAUSE && armed) |=> (curState == ALM_SOUND));

  // R5 R7
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (curState != ALM_REST && !armed) |=> (curState == ALM_REST));

  // R8
  doorIgnored_chk: assert property (@(posedge clk) disable iff (rst)
    (curState != ALM_REST && armed) |=> (curState != ALM_REST));

endmodule

// File: tb/doorAlarm_bench.sv
module doorAlarm_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic armed = 1'b0;
  logic doorOpen = 1'b0;
  logic horn;

  int total = 0;
  int bad = 0;
  int mState = 0; // 0 rest, 1 sounding, 2 pause
  bit done = 1'b0;

  always #10 clk = ~clk;

  doorAlarm u_doorAlarm (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .doorOpen (doorOpen),
    .horn     (horn)
  );

  function automatic int nextState(int s, bit a, bit d);
    case (s)
      0:       return (a && d) ? 1 : 0;
      1:       return a ? 2 : 0;
      2:       return a ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(int s, bit a, bit d);
    case (s)
      0:       return (a && d) ? "R3" : "R2";
      1:       return a ? "R4/R8" : "R5/R8";
      default: return a ? "R6/R8" : "R7/R8";
    endcase
  endfunction

  task automatic check(string req, bit exp);
    total++;
    if (horn !== exp) begin
      bad++;
      $display("FAIL %s: horn=%0b expected=%0b", req, horn, exp);
    end
  endtask

  task automatic tick(bit a, bit d, string req);
    armed = a;
    doorOpen = d;
    @(posedge clk);
    #2;
    mState = nextState(mState, a, d);
    check(req, mState == 1);
  endtask

  task automatic doReset();
    rst = 1'b1;
    armed = 1'b1;
    doorOpen = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    mState = 0;
    check("R1", 1'b0);
  endtask

  task automatic goTo(int s);
    doReset();
    if (s >= 1) tick(1'b1, 1'b1, "R3");
    if (s == 2) tick(1'b1, 1'b0, "R4");
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    @(posedge clk);
    @(posedge clk);
    #2;
    // R1: reset held with both inputs high still yields rest
    doReset();

    // full sweep over state x inputs, each followed by a probe clock
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 2; a++) begin
        for (int d = 0; d < 2; d++) begin
          goTo(s);
          tick(bit'(a), bit'(d), reqOf(s, bit'(a), bit'(d)));
          tick(1'b1, 1'b0, {"R9 probe ", reqOf(mState, 1'b1, 1'b0)});
        end
      end
    end

    // R9 and R8: long armed run with the door toggling each clock
    goTo(0);
    tick(1'b1, 1'b1, "R3");
    for (int i = 0; i < 12; i++) begin
      tick(1'b1, bit'(i % 2), "R9/R8 alternation");
    end
    tick(1'b0, 1'b1, "R5/R7 disarm");
    tick(1'b1, 1'b0, "R2 after disarm");

    done = 1'b1;
    report();
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      report();
    end
  end

endmodule